// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block collects interrupt causes for a network controller and drives one level-sensitive interrupt line. It holds a cause register and a mask register of `CAUSE_W` bits each, reached through a simple register-access port. The port has a read strobe, a write strobe, a word offset and data. Datapath logic outside the block raises cause bits through a vector of single-cycle event strobes. The interrupt line is high while any cause bit is also enabled in the mask.

Software sees four offsets. A write at one offset ORs bits into the cause register (force-set). Writes at two others set or clear mask bits. The cause offset acknowledges on write: every bit written as 1 is cleared. A read at the cause offset returns the causes and empties the register. The top bit of the cause register is a summary bit. It is recomputed on every update: it is 1 if the register holds any nonzero value and 0 otherwise. A hardware event that arrives in the same cycle as a read or an acknowledge is never lost.

Top module: `irq_cause_unit`

## Requirements
- R1: After every update the summary bit (bit `CAUSE_W-1`) is 1 exactly when the new cause value is nonzero. Acknowledging only the summary bit while other causes remain leaves it set. Acknowledging the last ordinary cause while the summary bit is set leaves the value equal to the summary bit alone.
- R2: `irqOut` is high exactly when the AND of mask and cause is nonzero. It reflects a register update from the cycle after the access.
- R3: A write at offset 1 (force-set) ORs the written data into the cause register.
- R4: A read at offset 0 returns the current cause value on `regRdData` in the same cycle. The cause register is zero from the next cycle on, unless a force or an event adds bits in that cycle.
- R5: A write at offset 0 (acknowledge) clears each cause bit written as 1 and keeps the others.
- R6: A write at offset 2 ORs the data into the mask, and a write at offset 3 clears the mask bits written as 1. A read at offset 2 returns the mask.
- R7: An event strobe bit `evtIn[i]` sets cause bit i at the next edge. This holds even when the same cycle carries a cause read or an acknowledge of that bit.
- R8: Reset, asynchronous and active low, clears cause and mask, and `irqOut` is low while reset is held and after it.
- R9: Reads at offsets 1 and 3 and at any unused offset return zero. Writes at unused offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word offset |
| regWrData | input | CAUSE_W | Write data |
| regRdData | output | CAUSE_W | Read data, valid in the cycle of `regRdEn` |
| evtIn | input | CAUSE_W-1 | Hardware cause event strobes |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench builds the block with the defaults `CAUSE_W = 32` and `ADDR_W = 4`. This places the summary bit at bit 31. A mask bit at that position then makes every pending cause visible on the line, so the self-restoring summary corners of R1 can be seen on `irqOut`. The 4-bit offset leaves twelve unused offsets, which brings the ignored write and zero read of R9 within reach.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  // Register word offsets; software decodes these
  localparam int unsigned OFS_CAUSE = 0;
  localparam int unsigned OFS_FORCE = 1;
  localparam int unsigned OFS_MSET  = 2;
  localparam int unsigned OFS_MCLR  = 3;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_MASK  = 2'd2
  } rdSelT;

  // Strobes from control to datapath
  typedef struct packed {
    logic  ackCause;
    logic  forceSet;
    logic  maskSet;
    logic  maskClr;
    logic  readCause;
    rdSelT rdSel;
  } regStrobeT;

endpackage

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobeT         strb
);

  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(OFS_FORCE);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MCLR);

  logic hitCause, hitForce, hitMset, hitMclr;

  assign hitCause = (regAddr == A_CAUSE);
  assign hitForce = (regAddr == A_FORCE);
  assign hitMset  = (regAddr == A_MSET);
  assign hitMclr  = (regAddr == A_MCLR);

  always_comb begin
    strb           = '0;
    strb.ackCause  = regWrEn & hitCause;
    strb.forceSet  = regWrEn & hitForce;
    strb.maskSet   = regWrEn & hitMset;
    strb.maskClr   = regWrEn & hitMclr;
    strb.readCause = regRdEn & hitCause;
    if (regRdEn && hitCause)     strb.rdSel = RD_CAUSE;
    else if (regRdEn && hitMset) strb.rdSel = RD_MASK;
    else                         strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_cause_datapath.sv
module irq_cause_datapath
  import irq_cause_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strb,
  input  logic [CAUSE_W-1:0] wrData,
  input  logic [CAUSE_W-2:0] evtIn,
  output logic [CAUSE_W-1:0] rdData,
  output logic               irqOut
);

  localparam int unsigned        SUM_BIT  = CAUSE_W - 1;
  localparam logic [CAUSE_W-1:0] SUM_MASK = {1'b1, {(CAUSE_W-1){1'b0}}};

  logic [CAUSE_W-1:0] causeQ, causeRaw, causeD;
  logic [CAUSE_W-1:0] maskQ, maskD;
  logic [CAUSE_W-1:0] evtWide;

  assign evtWide = CAUSE_W'(evtIn);

  // Ordering: read-clear, then acknowledge, then force, then events win
  always_comb begin
    causeRaw = causeQ;
    if (strb.readCause) causeRaw = '0;
    if (strb.ackCause)  causeRaw = causeRaw & ~wrData;
    if (strb.forceSet)  causeRaw = causeRaw | wrData;
    causeRaw = causeRaw | evtWide;
    causeD          = causeRaw;
    causeD[SUM_BIT] = |causeRaw;
  end

  always_comb begin
    maskD = maskQ;
    if (strb.maskSet) maskD = maskD | wrData;
    if (strb.maskClr) maskD = maskD & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
    end else begin
      causeQ <= causeD;
      maskQ  <= maskD;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CAUSE: rdData = causeQ;
      RD_MASK:  rdData = maskQ;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |(maskQ & causeQ);

  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (causeQ != '0) |-> causeQ[SUM_BIT]); // R1

  AST_FORCE_ORS: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceSet |=> ((causeQ & $past(wrData)) == $past(wrData))); // R3

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readCause && !strb.forceSet && evtIn == '0) |=> (causeQ == '0)); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackCause && !strb.forceSet && !strb.readCause)
      |=> ((causeQ & $past(wrData) & ~SUM_MASK & ~$past(evtWide)) == '0)); // R5

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskSet |=> ((maskQ & $past(wrData)) == $past(wrData))); // R6

  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskClr |=> ((maskQ & $past(wrData)) == '0)); // R6

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((causeQ & $past(evtWide)) == $past(evtWide))); // R7

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CAUSE_W-1:0] regWrData,
  output logic [CAUSE_W-1:0] regRdData,
  input  logic [CAUSE_W-2:0] evtIn,
  output logic               irqOut
);

  regStrobeT strb;

  irq_cause_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_cause_datapath #(.CAUSE_W(CAUSE_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .evtIn  (evtIn),
    .rdData (regRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_irq_cause_unit.sv
module tb_irq_cause_unit;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [CW-1:0] regWrData = '0;
  logic [CW-1:0] regRdData;
  logic [CW-2:0] evtIn = '0;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  irq_cause_unit #(.CAUSE_W(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtIn(evtIn), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [AW-1:0] OC = 4'd0, OF = 4'd1, OS = 4'd2, OK = 4'd3, OX = 4'd5;

  typedef struct packed {
    logic          isWr;
    logic [AW-1:0] addr;
    logic [CW-1:0] data;
    logic [CW-1:0] expRd;
    logic          expIrq;
    logic [3:0]    req;
  } vecT;

  localparam int NV = 24;
  localparam vecT VEC [NV] = '{
    '{1'b1, OS, 32'h0000_0003, 32'h0, 1'b0, 4'd6},   // R6 mask set
    '{1'b0, OS, 32'h0,         32'h0000_0003, 1'b0, 4'd6}, // R6 readback
    '{1'b1, OF, 32'h0000_0004, 32'h0, 1'b0, 4'd2},   // R2 unmasked cause
    '{1'b0, OF, 32'h0,         32'h0, 1'b0, 4'd9},   // R9 write-only reads 0
    '{1'b1, OF, 32'h0000_0001, 32'h0, 1'b1, 4'd3},   // R3 force ORs
    '{1'b1, OK, 32'h0000_0001, 32'h0, 1'b0, 4'd6},   // R6 mask clear
    '{1'b1, OS, 32'h0000_0004, 32'h0, 1'b1, 4'd2},   // R2 enable pending
    '{1'b1, OC, 32'h0000_0004, 32'h0, 1'b0, 4'd5},   // R5 ack one bit
    '{1'b0, OC, 32'h0,         32'h8000_0001, 1'b0, 4'd4}, // R4 read value
    '{1'b0, OC, 32'h0,         32'h0, 1'b0, 4'd4},   // R4 read emptied
    '{1'b1, OF, 32'h0000_0010, 32'h0, 1'b0, 4'd3},   // R3
    '{1'b1, OS, 32'h8000_0000, 32'h0, 1'b1, 4'd1},   // R1 summary enabled
    '{1'b1, OC, 32'h0000_0010, 32'h0, 1'b1, 4'd1},   // R1 summary alone stays
    '{1'b0, OC, 32'h0,         32'h8000_0000, 1'b0, 4'd1}, // R1
    '{1'b1, OF, 32'h8000_0000, 32'h0, 1'b1, 4'd1},   // R1 force summary only
    '{1'b1, OC, 32'h8000_0000, 32'h0, 1'b0, 4'd1},   // R1 ack to zero
    '{1'b1, OF, 32'h0000_0022, 32'h0, 1'b1, 4'd3},   // R3
    '{1'b1, OC, 32'h8000_0000, 32'h0, 1'b1, 4'd1},   // R1 summary re-set
    '{1'b0, OC, 32'h0,         32'h8000_0022, 1'b0, 4'd1}, // R1
    '{1'b1, OX, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd9},   // R9 unused write
    '{1'b0, OX, 32'h0,         32'h0, 1'b0, 4'd9},   // R9 unused read
    '{1'b0, OS, 32'h0,         32'h8000_0006, 1'b0, 4'd9}, // R9 mask untouched
    '{1'b0, OC, 32'h0,         32'h0, 1'b0, 4'd9},   // R9 cause untouched
    '{1'b0, OK, 32'h0,         32'h0, 1'b0, 4'd9}    // R9 write-only reads 0
  };

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [AW-1:0] a, input logic [CW-1:0] d,
                       input logic [CW-2:0] e);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; evtIn = e;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evtIn = '0;
  endtask

  task automatic rdReg(input logic [AW-1:0] a, input logic [CW-2:0] e,
                       output logic [CW-1:0] got);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a; evtIn = e;
    #1 got = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; evtIn = '0;
  endtask

  initial begin
    logic [CW-1:0] got;
    repeat (3) @(negedge clk);
    // R8: state under reset and after release
    check(irqOut == 1'b0, "R8 irq in reset", CW'(irqOut), 0);
    rstN = 1'b1;
    rdReg(OC, '0, got); check(got == 0, "R8 cause after reset", got, 0);
    rdReg(OS, '0, got); check(got == 0, "R8 mask after reset", got, 0);
    check(irqOut == 1'b0, "R8 irq after reset", CW'(irqOut), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) wrReg(VEC[i].addr, VEC[i].data, '0);
      else begin
        rdReg(VEC[i].addr, '0, got);
        check(got == VEC[i].expRd, $sformatf("R%0d row %0d read", VEC[i].req, i),
              got, VEC[i].expRd);
      end
      check(irqOut == VEC[i].expIrq, $sformatf("R%0d row %0d irq", VEC[i].req, i),
            CW'(irqOut), CW'(VEC[i].expIrq));
    end

    // R7: lone event raises its bit (mask is 0x80000006)
    @(negedge clk); evtIn = 31'h2; @(negedge clk); evtIn = '0;
    check(irqOut == 1'b1, "R7 event raises irq", CW'(irqOut), 1);
    // R7: event in the same cycle as a cause read survives
    rdReg(OC, 31'h8, got);
    check(got == 32'h8000_0002, "R7 read old value", got, 32'h8000_0002);
    check(irqOut == 1'b1, "R2 summary enabled irq", CW'(irqOut), 1);
    rdReg(OC, '0, got);
    check(got == 32'h8000_0008, "R7 event kept over read", got, 32'h8000_0008);
    // R7: event on the bit being acknowledged wins
    wrReg(OF, 32'h20, '0);
    wrReg(OC, 32'h20, 31'h20);
    rdReg(OC, '0, got);
    check(got == 32'h8000_0020, "R7 event kept over ack", got, 32'h8000_0020);
    // R3 with concurrent event
    wrReg(OF, 32'h1, 31'h4);
    rdReg(OC, '0, got);
    check(got == 32'h8000_0005, "R3 force with event", got, 32'h8000_0005);

    // R8: reset mid-run
    wrReg(OF, 32'h1, '0);
    check(irqOut == 1'b1, "R8 irq before reset", CW'(irqOut), 1);
    rstN = 1'b0;
    #1 check(irqOut == 1'b0, "R8 irq drops in reset", CW'(irqOut), 0);
    @(negedge clk); rstN = 1'b1;
    rdReg(OS, '0, got); check(got == 0, "R8 mask cleared", got, 0);
    rdReg(OC, '0, got); check(got == 0, "R8 cause cleared", got, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule